// File: doc/BRIEF.md
# Receive Buffer Credit Flow Control

This block keeps, for each flow-control group, a running count of the free receive buffers that software has handed to the receive DMA engine. Each group serves one pair of DMA channels; the even channel of the pair is the receiving one, and the group index is the channel number shifted right by one. Software returns buffers by writing a count into the group's allocation register. The receive engine pulses a per-group consume input each time it fills a buffer. Each write updates the count, and so does each consume pulse.

From that count the block drives a per-group pause line toward the receive engine. It uses two programmable levels. Pause rises when the count drops below the low level. It stays up until the count climbs back to the high level or above, which gives hysteresis between the two levels. When a channel is shut down, software sets the top bit of the allocation register. This override holds pause low until the next ordinary allocation write. Pause only acts when the controller and the group are both enabled in a shared configuration word.

Top module: `rx_credit_fc`

## Requirements
- R1: After reset every count, every threshold and every enable bit is zero, and every pause output is low.
- R2: Writes decode as follows. Address 0x00 is the configuration word: bit 0 is the controller enable and bit g+1 enables group g. Group g has its low level at 0x04+12g, its high level at 0x08+12g and its allocation register at 0x0C+12g. A write to any other address changes nothing.
- R3: An allocation write with bit 31 clear adds bits 30:0 to the group's count and saturates at 2^CNT_W-1. A value of 0 leaves the count unchanged. Threshold writes take bits 30:0, clamped to the same ceiling.
- R4: Each consume pulse lowers the group's count by one, and the count never drops below zero.
- R5: An allocation write of N and a consume pulse in the same cycle give count+N-1, limited to the range 0 to 2^CNT_W-1.
- R6: In an active group, pause is high from the clock edge at which the count becomes lower than the low level.
- R7: Pause stays in its previous state while the count lies between the low level (inclusive) and the high level (exclusive). It drops at the edge at which the count reaches the high level or goes above it.
- R8: An allocation write with bit 31 set leaves the count unchanged and forces pause low from the next edge. The force holds until an allocation write with bit 31 clear, after which pause is evaluated again at that write's edge.
- R9: When the group enable bit or the controller enable bit is clear, the group's pause is low from the edge that clears the bit. The group's hysteresis state is cleared as well.
- R10: Groups are independent: consume pulses and writes to one group leave the count of every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the register written |
| wr_data | input | 32 | Write data |
| rx_consume | input | NUM_GROUPS | One-cycle pulse per group when the receive engine takes a buffer |
| rx_pause | output | NUM_GROUPS | Per-group request to the receive engine to stop taking buffers |

## Verification
An allocation write and a consume pulse can land on the same group in the same cycle. The count must then move by the net amount, and the pause decision must use that net value. The bench drives both in one cycle on a group that holds a known count. It then reads the resulting count back through the ports by setting both levels to one value and watching pause. It also drives a consume pulse at a count of zero and an allocation write at the ceiling, to check both saturation limits.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    REG_LOW   = 2'd0,
    REG_HIGH  = 2'd1,
    REG_ALLOC = 2'd2
  } grp_reg_e;

  localparam int unsigned CFG_ADDR   = 0;
  localparam int unsigned GRP_BASE   = 4;
  localparam int unsigned GRP_STRIDE = 12;
  localparam int          DATA_W     = 32;
  localparam int          FORCE_BIT  = 31;

  // Byte address of one register of group g.
  function automatic int unsigned grp_reg_addr(int unsigned g, grp_reg_e kind);
    return GRP_BASE + GRP_STRIDE * g + 4 * 32'(kind);
  endfunction

  // Clamp a value to a ceiling.
  function automatic longint unsigned clamp_to(longint unsigned v, longint unsigned ceiling);
    return (v > ceiling) ? ceiling : v;
  endfunction

  // Net credit update: add, then take one if consumed, floor 0, ceiling clamp.
  function automatic longint unsigned credit_next(longint unsigned cur, longint unsigned add,
                                                   logic take, longint unsigned ceiling);
    longint unsigned s;
    s = cur + add;
    if (take && (s != 0)) s = s - 1;
    return clamp_to(s, ceiling);
  endfunction

  // Hysteresis: below low -> pause, at or above high -> release, else hold.
  function automatic logic hyst_next(logic prev, longint unsigned cnt,
                                     longint unsigned lo, longint unsigned hi);
    if (cnt < lo)       return 1'b1;
    else if (cnt >= hi) return 1'b0;
    else                return prev;
  endfunction

endpackage

// File: rtl/fcc_regdec.sv
module fcc_regdec
  import fcc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [NUM_GROUPS:0]   cfg_bits,
  output logic                  glob_en,
  output logic [NUM_GROUPS-1:0] grp_en,
  output logic [NUM_GROUPS-1:0] low_stb,
  output logic [NUM_GROUPS-1:0] high_stb,
  output logic [NUM_GROUPS-1:0] alloc_stb
);

  logic cfg_hit;
  assign cfg_hit = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      grp_en  <= '0;
    end else if (cfg_hit) begin
      glob_en <= cfg_bits[0];
      grp_en  <= cfg_bits[NUM_GROUPS:1];
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign low_stb[g]   = wr_en && (wr_addr == ADDR_W'(grp_reg_addr(g, REG_LOW)));
    assign high_stb[g]  = wr_en && (wr_addr == ADDR_W'(grp_reg_addr(g, REG_HIGH)));
    assign alloc_stb[g] = wr_en && (wr_addr == ADDR_W'(grp_reg_addr(g, REG_ALLOC)));
  end

endmodule

// File: rtl/fcc_group.sv
module fcc_group
  import fcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        low_stb,
  input  logic        high_stb,
  input  logic        alloc_stb,
  input  logic [31:0] wr_data,
  input  logic        consume,
  output logic        pause_o
);

  localparam longint unsigned CNT_MAX = (64'd1 << CNT_W) - 64'd1;

  logic [CNT_W-1:0] cnt_q, cnt_d, low_q, high_q;
  logic             force_q, force_d, hold_q, hold_d;
  logic [30:0]      wr_val;

  // Named events for the assertions.
  logic add_stb, force_stb, consume_hit;
  assign wr_val      = wr_data[30:0];
  assign add_stb     = alloc_stb && !wr_data[FORCE_BIT];
  assign force_stb   = alloc_stb &&  wr_data[FORCE_BIT];
  assign consume_hit = consume;

  always_comb begin
    cnt_d   = CNT_W'(credit_next(64'(cnt_q), add_stb ? 64'(wr_val) : 64'd0,
                                 consume_hit, CNT_MAX));
    force_d = force_stb ? 1'b1 : (add_stb ? 1'b0 : force_q);
    hold_d  = (active && !force_d) ?
              hyst_next(hold_q, 64'(cnt_d), 64'(low_q), 64'(high_q)) : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      low_q   <= '0;
      high_q  <= '0;
      force_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      force_q <= force_d;
      hold_q  <= hold_d;
      if (low_stb)  low_q  <= CNT_W'(clamp_to(64'(wr_val), CNT_MAX));
      if (high_stb) high_q <= CNT_W'(clamp_to(64'(wr_val), CNT_MAX));
    end
  end

  assign pause_o = hold_q && active && !force_q;

  // R4: floor at zero
  assert_floor_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) && consume_hit && !add_stb |=> (cnt_q == '0));

  // R4: plain decrement
  assert_consume_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && consume_hit && !add_stb |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: plain add below the ceiling
  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    add_stb && !consume_hit && ((64'(cnt_q) + 64'(wr_val)) <= CNT_MAX)
    |=> (64'(cnt_q) == $past(64'(cnt_q) + 64'(wr_val))));

  // R5: add and consume together
  assert_net_R5: assert property (@(posedge clk) disable iff (!rst_n)
    add_stb && consume_hit && ((64'(cnt_q) + 64'(wr_val)) >= 64'd1)
    && ((64'(cnt_q) + 64'(wr_val)) <= CNT_MAX + 64'd1)
    |=> (64'(cnt_q) == $past(64'(cnt_q) + 64'(wr_val)) - 64'd1));

  // R8: force write drops pause on the next edge
  assert_force_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_stb |=> !pause_o);

  // R6: pause is only entered below the low level
  assert_pause_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) && $stable(low_q) |-> (cnt_q < low_q));

endmodule

// File: rtl/rx_credit_fc.sv
module rx_credit_fc
  import fcc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [NUM_GROUPS-1:0] rx_consume,
  output logic [NUM_GROUPS-1:0] rx_pause
);

  logic                  glob_en;
  logic [NUM_GROUPS-1:0] grp_en, low_stb, high_stb, alloc_stb;

  fcc_regdec #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cfg_bits  (wr_data[NUM_GROUPS:0]),
    .glob_en   (glob_en),
    .grp_en    (grp_en),
    .low_stb   (low_stb),
    .high_stb  (high_stb),
    .alloc_stb (alloc_stb)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    fcc_group #(.CNT_W(CNT_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (glob_en && grp_en[g]),
      .low_stb   (low_stb[g]),
      .high_stb  (high_stb[g]),
      .alloc_stb (alloc_stb[g]),
      .wr_data   (wr_data),
      .consume   (rx_consume[g]),
      .pause_o   (rx_pause[g])
    );
  end

endmodule

// File: tb/tb_rx_credit_fc.sv
`timescale 1ns/1ps
module tb_rx_credit_fc;

  localparam int G = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [G-1:0]  rx_consume = '0;
  logic [G-1:0]  rx_pause;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_credit_fc #(.NUM_GROUPS(G), .ADDR_W(AW), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_consume(rx_consume), .rx_pause(rx_pause)
  );

  function automatic logic [AW-1:0] a_low(int g);   return AW'(4 + 12*g);  endfunction
  function automatic logic [AW-1:0] a_high(int g);  return AW'(8 + 12*g);  endfunction
  function automatic logic [AW-1:0] a_alloc(int g); return AW'(12 + 12*g); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set_levels(int g, int lo, int hi);
    wr(a_low(g), 32'(lo));
    wr(a_high(g), 32'(hi));
  endtask

  // Read a count through the ports: with both levels at T, pause == (count < T).
  task automatic probe(int g, int exp, string req);
    set_levels(g, exp, exp);
    idle(1);
    chk(req, 32'(rx_pause[g]), 32'd0);
    set_levels(g, exp + 1, exp + 1);
    idle(1);
    chk(req, 32'(rx_pause[g]), 32'd1);
    set_levels(g, 0, 0);
    idle(1);
  endtask

  task automatic t_reset();
    chk("R1 pause after reset", 32'(rx_pause), 32'd0);
    wr(8'h00, 32'h1F);
    idle(1);
    chk("R1 zero levels give no pause", 32'(rx_pause), 32'd0);
    probe(0, 0, "R1 count zero");
  endtask

  task automatic t_map();
    set_levels(1, 1, 1);
    idle(1);
    chk("R2 group1 level addresses", 32'(rx_pause), 32'b0010);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h34, 32'h0000_0001);
    wr(8'h40, 32'h0000_0001);
    idle(1);
    chk("R2 unmapped writes ignored", 32'(rx_pause), 32'b0010);
    wr(a_alloc(1), 32'd1);
    chk("R2 R3 group1 alloc address", 32'(rx_pause[1]), 32'd0);
  endtask

  task automatic t_alloc();
    wr(a_alloc(0), 32'd3);
    wr(a_alloc(0), 32'd0);
    probe(0, 3, "R3 add and zero write");
  endtask

  task automatic t_same_cycle();
    wr_en = 1'b1; wr_addr = a_alloc(0); wr_data = 32'd4; rx_consume = 4'b0001;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rx_consume = '0;
    probe(0, 6, "R5 net add and consume");
  endtask

  task automatic t_floor();
    for (int i = 0; i < 3; i++) begin
      rx_consume = 4'b1000; @(negedge clk); rx_consume = '0;
    end
    wr(a_alloc(3), 32'd2);
    probe(3, 2, "R4 floor at zero");
    probe(0, 6, "R10 other group untouched");
  endtask

  task automatic t_saturate();
    wr(a_alloc(2), 32'h0000_FFFF);
    wr(a_alloc(2), 32'd5);
    set_levels(2, 65535, 65535);
    idle(1);
    chk("R3 saturates at ceiling", 32'(rx_pause[2]), 32'd0);
    rx_consume = 4'b0100; @(negedge clk); rx_consume = '0;
    chk("R4 decrement from ceiling", 32'(rx_pause[2]), 32'd1);
    set_levels(2, 0, 0);
    idle(1);
  endtask

  task automatic t_hyst();
    set_levels(1, 2, 4);
    idle(1);
    chk("R6 below low pauses", 32'(rx_pause[1]), 32'd1);
    wr(a_alloc(1), 32'd2);
    chk("R7 in band stays paused", 32'(rx_pause[1]), 32'd1);
    wr(a_alloc(1), 32'd1);
    chk("R7 release at high", 32'(rx_pause[1]), 32'd0);
    rx_consume = 4'b0010; @(negedge clk); rx_consume = '0;
    chk("R7 in band stays released", 32'(rx_pause[1]), 32'd0);
    rx_consume = 4'b0010; @(negedge clk); rx_consume = '0;
    chk("R7 at low still released", 32'(rx_pause[1]), 32'd0);
    rx_consume = 4'b0010; @(negedge clk); rx_consume = '0;
    chk("R6 pause at the consume edge", 32'(rx_pause[1]), 32'd1);
  endtask

  task automatic t_force();
    wr(a_alloc(1), 32'h8000_0005);
    chk("R8 force drops pause", 32'(rx_pause[1]), 32'd0);
    idle(3);
    chk("R8 force held", 32'(rx_pause[1]), 32'd0);
    wr(a_alloc(1), 32'd0);
    chk("R8 plain write removes force", 32'(rx_pause[1]), 32'd1);
    probe(1, 1, "R8 force write leaves count");
  endtask

  task automatic t_enable();
    set_levels(1, 2, 4);
    idle(1);
    chk("R9 setup paused", 32'(rx_pause[1]), 32'd1);
    wr(8'h00, 32'h1B);
    chk("R9 group enable off", 32'(rx_pause[1]), 32'd0);
    wr(8'h00, 32'h1F);
    idle(1);
    chk("R9 group enable back on", 32'(rx_pause[1]), 32'd1);
    wr(8'h00, 32'h1E);
    chk("R9 controller enable off", 32'(rx_pause), 32'd0);
    wr(8'h00, 32'h1F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_alloc();
    t_same_cycle();
    t_floor();
    t_saturate();
    t_hyst();
    t_force();
    t_enable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule